// File: doc/BRIEF.md
# Two-Rail Self-Checking Parity Checker

This block watches an N-bit codeword protected by one parity bit and reports on a pair of complementary wires instead of a single error flag. The codeword is cut into a low group and a high group. Each group feeds its own XOR tree, and the two tree results leave the block as the rails `rail_g` and `rail_h`. A fault-free checker that sees a good codeword drives the rails to 01 or 10. Any odd number of flipped bits, and therefore any single-bit error, drives them to 00 or 11. A stuck node inside one tree can upset only its own rail, so the damage appears as an invalid pair the next time a suitable codeword arrives. It is never hidden behind a constant flag.

The parameter `EVEN_PARITY` picks the code. For even parity the high-group rail is inverted; for odd parity it is used as it comes out of its tree. The pair is captured in a register, with `out_vld` marking the cycles that carry a fresh result. A convenience flag `pair_ok` (the XOR of the two rails) is registered next to the pair. It is meant for test and sits outside the self-checking path. For bench use, the parameter `FAULT` can force either tree output to a constant.

Top module: `tr_parity_checker`

## Requirements
- R1: With M = N/2, `rail_g` is the XOR of `cw_in[M-1:0]`. The high rail is formed from the XOR of `cw_in[N-1:M]`. N must be at least 2.
- R2: When EVEN_PARITY=1, the high rail is the inverse of its tree output. Every codeword with an even number of ones then gives a complementary pair (01 or 10).
- R3: When EVEN_PARITY=0, the high rail equals its tree output. Every codeword with an odd number of ones then gives a complementary pair.
- R4: Every word that is one bit away from a valid codeword gives 00 or 11 on the rails.
- R5: A word sampled with `in_vld` high appears on the rails one clock later, with `out_vld` high in that cycle only.
- R6: While `in_vld` is low, `out_vld` is low and the rails keep their last value, whatever `cw_in` does.
- R7: Synchronous active-high reset clears `rail_g`, `rail_h`, `out_vld` and `pair_ok` to 0.
- R8: `pair_ok` is 1 exactly when the registered rails differ.
- R9: When either tree output is forced to 0 or to 1, at least one valid codeword gives a non-complementary pair.
- R10: When reset and `in_vld` are high in the same cycle, reset wins: the next cycle shows all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_in | input | N | Codeword under test |
| in_vld | input | 1 | Sample `cw_in` this cycle |
| rail_g | output | 1 | Registered low-group rail |
| rail_h | output | 1 | Registered high-group rail (inverted for even parity) |
| out_vld | output | 1 | Rails carry a new result |
| pair_ok | output | 1 | Registered XOR of the rails, for test only |

## Verification
Two functions can land in the same cycle. The first case is reset arriving together with a sampled word. It is provoked by raising `rst` and `in_vld` at the same falling edge, and the bench then expects all outputs at 0 one clock later, with no result queued. The second case is a codeword error arriving on top of a stuck tree output. The bench sweeps all 2^N words through fault-free even and odd checkers, and also through four checkers with forced tree outputs. The fault-free checkers are compared bit for bit against rails predicted from the partition rule. Each faulty checker must show a non-complementary pair on at least one even-weight word.

// File: rtl/tr_pkg.sv
package tr_pkg;
  // Which tree output, if any, is forced to a constant (bench fault model)
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_G0   = 3'd1,
    FLT_G1   = 3'd2,
    FLT_H0   = 3'd3,
    FLT_H1   = 3'd4
  } tr_fault_e;
endpackage

// File: rtl/tr_xor_tree.sv
module tr_xor_tree #(
  parameter int W = 4
) (
  input  logic [W-1:0] bits,
  output logic         parity
);
  localparam int LVL    = (W > 1) ? $clog2(W) : 0;
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES - 1;

  // heap layout: node i has children 2i+1 and 2i+2, leaves at the tail
  logic node [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < W) begin : g_real
      assign node[LEAVES-1+j] = bits[j];
    end else begin : g_pad
      assign node[LEAVES-1+j] = 1'b0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    assign node[i] = node[2*i+1] ^ node[2*i+2];
  end

  assign parity = node[0];
endmodule

// File: rtl/tr_rail_fault.sv
module tr_rail_fault #(
  parameter tr_pkg::tr_fault_e FAULT = tr_pkg::FLT_NONE,
  parameter bit                HIGH  = 1'b0
) (
  input  logic d,
  output logic q
);
  // Forces the tree output of one rail when FAULT targets that rail
  if ((!HIGH && FAULT == tr_pkg::FLT_G0) || (HIGH && FAULT == tr_pkg::FLT_H0)) begin : g_sa0
    assign q = 1'b0;
  end else if ((!HIGH && FAULT == tr_pkg::FLT_G1) || (HIGH && FAULT == tr_pkg::FLT_H1)) begin : g_sa1
    assign q = 1'b1;
  end else begin : g_pass
    assign q = d;
  end
endmodule

// File: rtl/tr_rail_reg.sv
module tr_rail_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d_g,
  input  logic d_h,
  output logic q_g,
  output logic q_h,
  output logic q_vld,
  output logic q_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_g   <= 1'b0;
      q_h   <= 1'b0;
      q_vld <= 1'b0;
      q_ok  <= 1'b0;
    end else begin
      q_vld <= en;
      if (en) begin
        q_g  <= d_g;
        q_h  <= d_h;
        q_ok <= d_g ^ d_h;
      end
    end
  end
endmodule

// File: rtl/tr_parity_checker.sv
module tr_parity_checker #(
  parameter int                N           = 9,
  parameter bit                EVEN_PARITY = 1'b1,
  parameter tr_pkg::tr_fault_e FAULT       = tr_pkg::FLT_NONE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cw_in,
  input  logic         in_vld,
  output logic         rail_g,
  output logic         rail_h,
  output logic         out_vld,
  output logic         pair_ok
);
  localparam int M  = N / 2;
  localparam int WL = M;
  localparam int WH = N - M;

  initial assert (N >= 2); // R1

  logic tree_lo, tree_hi;
  logic lo_f, hi_f;
  logic g_nxt, h_nxt;

  tr_xor_tree #(.W(WL)) lo_tree_i (.bits(cw_in[M-1:0]), .parity(tree_lo));
  tr_xor_tree #(.W(WH)) hi_tree_i (.bits(cw_in[N-1:M]), .parity(tree_hi));

  tr_rail_fault #(.FAULT(FAULT), .HIGH(1'b0)) lo_flt_i (.d(tree_lo), .q(lo_f));
  tr_rail_fault #(.FAULT(FAULT), .HIGH(1'b1)) hi_flt_i (.d(tree_hi), .q(hi_f));

  assign g_nxt = lo_f;
  if (EVEN_PARITY) begin : g_even
    assign h_nxt = ~hi_f;
  end else begin : g_odd
    assign h_nxt = hi_f;
  end

  tr_rail_reg out_reg_i (
    .clk(clk), .rst(rst), .en(in_vld),
    .d_g(g_nxt), .d_h(h_nxt),
    .q_g(rail_g), .q_h(rail_h), .q_vld(out_vld), .q_ok(pair_ok)
  );

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable({rail_g, rail_h}))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!rail_g && !rail_h && !out_vld && !pair_ok)); // R7

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (pair_ok == (rail_g ^ rail_h))); // R8

  if (FAULT == tr_pkg::FLT_NONE) begin : g_chk
    AST_CODE_MAP: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> ((rail_g ^ rail_h) ==
                  (EVEN_PARITY ? ~^$past(cw_in) : ^$past(cw_in)))); // R2
  end
endmodule

// File: tb/tr_parity_checker_tb_top.sv
`timescale 1ns/1ps
module tr_parity_checker_tb_top;
  localparam int N = 9;
  localparam int M = N / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [N-1:0] cw = '0;

  logic e_g, e_h, e_ov, e_ok;
  logic o_g, o_h, o_ov, o_ok;
  logic f_g [4];
  logic f_h [4];
  logic f_ov [4];
  logic f_ok [4];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit exposed [4];
  logic [N-1:0] sb [$];

  always #5 clk = ~clk;

  tr_parity_checker #(.N(N), .EVEN_PARITY(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cw_in(cw), .in_vld(in_vld),
    .rail_g(e_g), .rail_h(e_h), .out_vld(e_ov), .pair_ok(e_ok));

  tr_parity_checker #(.N(N), .EVEN_PARITY(1'b0)) odd_i (
    .clk(clk), .rst(rst), .cw_in(cw), .in_vld(in_vld),
    .rail_g(o_g), .rail_h(o_h), .out_vld(o_ov), .pair_ok(o_ok));

  for (genvar k = 0; k < 4; k++) begin : g_flt
    tr_parity_checker #(.N(N), .EVEN_PARITY(1'b1),
                        .FAULT(tr_pkg::tr_fault_e'(k + 1))) flt_i (
      .clk(clk), .rst(rst), .cw_in(cw), .in_vld(in_vld),
      .rail_g(f_g[k]), .rail_h(f_h[k]), .out_vld(f_ov[k]), .pair_ok(f_ok[k]));
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send(input logic [N-1:0] w);
    @(negedge clk);
    cw = w;
    in_vld = 1'b1;
    sb.push_back(w);
  endtask

  // Monitor: pops the oldest word and compares every checker's result
  always @(negedge clk) begin
    if (!rst && e_ov) begin
      if (sb.size() == 0) begin
        chk("R5 unexpected result", 4'd1, 4'd0);
      end else begin
        logic [N-1:0] w;
        logic pg, ph;
        w  = sb.pop_front();
        pg = ^w[M-1:0];
        ph = ^w[N-1:M];
        chk("R1 R2 even rails", {2'b00, e_g, e_h}, {2'b00, pg, ~ph});
        chk("R3 odd rails", {2'b00, o_g, o_h}, {2'b00, pg, ph});
        chk("R8 flag", {3'b000, e_ok}, {3'b000, pg ^ ~ph});
        if ($countones(w) % 2 == 1)
          chk("R4 error pair", {3'b000, e_g ^ e_h}, 4'd0);
        else
          for (int k = 0; k < 4; k++)
            if (f_g[k] == f_h[k]) exposed[k] = 1'b1;
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset state", {e_g, e_h, e_ov, e_ok}, 4'b0000);
    rst = 1'b0;

    // R5 R6: one word, then idle with a changing input
    send(9'h003);
    @(negedge clk);
    in_vld = 1'b0;
    cw = 9'h1FF;
    chk("R5 out_vld after one clock", {3'b000, e_ov}, 4'd1);
    chk("R5 rails of 0x003", {2'b00, e_g, e_h}, 4'b0001);
    @(negedge clk);
    cw = 9'h100;
    chk("R6 out_vld low when idle", {3'b000, e_ov}, 4'd0);
    chk("R6 rails held", {2'b00, e_g, e_h}, 4'b0001);
    @(negedge clk);
    chk("R6 rails still held", {2'b00, e_g, e_h}, 4'b0001);

    // Full sweep of every word through all checkers
    for (int w = 0; w < (1 << N); w++) send(w[N-1:0]);
    @(negedge clk);
    in_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 scoreboard drained", {3'b000, sb.size() != 0}, 4'd0);
    for (int k = 0; k < 4; k++)
      chk($sformatf("R9 stuck fault %0d exposed", k), {3'b000, exposed[k]}, 4'd1);

    // R10: reset and a sample in the same cycle
    send(9'h001);
    @(negedge clk);
    rst = 1'b1;
    in_vld = 1'b1;
    cw = 9'h003;
    void'(sb.pop_back());
    @(negedge clk);
    chk("R10 reset beats sample", {e_g, e_h, e_ov, e_ok}, 4'b0000);
    rst = 1'b0;
    in_vld = 1'b0;
    sb.delete();
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule